// File: doc/BRIEF.md
# Delay-Line Fine-Time Encoder

This block turns a snapshot of a tapped delay line into a binary fine-time code. The line rests with every tap high. When a hit enters, the taps drop to low one after another, starting at bit 0 and moving up. At each rising clock edge the block samples the taps, so the number of low taps counted from bit 0 shows how far the hit travelled during that clock period. The sample passes through a second register stage to reduce metastability. A pipelined binary search then locates the low-to-high boundary, and a final register presents the code together with a hit strobe and a flag for a line that has gone low from end to end.

The block accepts a new snapshot on every clock and produces one result on every clock, always after the same fixed number of cycles. The output is a plain per-cycle stream. There is no ready input, and nothing can be held back: a consumer must take each cycle's result in that cycle. The tap width `N` is a parameter and must be a power of two, at least 4.

Top module: `thermo_fine_encoder`

## Requirements
- R1: While `rst_n` is low, `fine_code`, `fine_valid` and `chain_overflow` are all 0, whatever `tap` carries.
- R2: A sample with every tap high (no hit) gives `fine_valid` = 0, `fine_code` = 0 and `chain_overflow` = 0.
- R3: A clean sample whose low taps are bits 0 to z-1, with 1 <= z <= N-1, gives `fine_valid` = 1, `fine_code` = z and `chain_overflow` = 0.
- R4: The result for the sample taken at rising edge k appears on the outputs right after rising edge k + log2(N) + 2. Samples on consecutive edges give results on consecutive edges.
- R5: A sample with every tap low gives `chain_overflow` = 1, `fine_valid` = 1 and `fine_code` = N-1, the saturated value.
- R6: A sample whose only high tap is bit N-1 gives `fine_code` = N-1 and `chain_overflow` = 0. The flag is raised only when the line is low from end to end.
- R7: Take a boundary at z, with 3 <= z <= N-2, and disturb it with a one-bit bubble next to it: bit z-1 reads high and bit z reads low. The code is then within one of z.
- R8: A sample with tap bit 0 high counts as no hit, whatever the upper bits hold: `fine_valid` = 0, `fine_code` = 0, `chain_overflow` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the taps are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tap | input | N | Delay-line taps; bit 0 is the entry end |
| fine_code | output | log2(N) | Number of low taps counted from bit 0, saturated at N-1 |
| fine_valid | output | 1 | A hit was seen in the sample that this result belongs to |
| chain_overflow | output | 1 | Every tap was low in that sample |

## Verification
The taps are driven with a back-to-back sweep of clean boundaries covering every position from 1 to N-1. This separates an off-by-one count or a wrong search step from a correct decode, and it shows the one-result-per-cycle rate. Runs of idle samples and a sample with bit 0 high but upper bits low separate the no-hit decision from the boundary search. The all-low and only-top-bit-high samples separate saturation from the overflow flag. Bubbles placed next to the boundary show the tolerance to a single bit in the wrong place. A lone hit between idle samples pins down the exact latency in cycles.

// File: rtl/thermo_fine_pkg.sv
package thermo_fine_pkg;
  // Per-sample side information carried alongside the search pipeline.
  typedef struct packed {
    logic hit;   // entry tap was low: a hit is present
    logic full;  // far-end tap was low: line ran out
  } fine_flags_t;
endpackage

// File: rtl/tap_sync.sv
module tap_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] first_q;

  // Both stages reset to the idle (all high) line state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '1;
      q       <= '1;
    end else begin
      first_q <= d;
      q       <= first_q;
    end
  end
endmodule

// File: rtl/fine_search.sv
module fine_search
  import thermo_fine_pkg::*;
#(
  parameter int N  = 64,
  parameter int CW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vec_i,
  input  fine_flags_t   flags_i,
  output logic [CW-1:0] acc_o,
  output fine_flags_t   flags_o
);
  // Stage i settles code bit CW-1-i, MSB first, by probing the tap just
  // below the candidate count.
  for (genvar i = 0; i < CW; i++) begin : g_step
    localparam int BIT = CW - 1 - i;
    localparam logic [CW-1:0] MASK = CW'(1) << BIT;

    logic [CW-1:0] acc_in;
    logic [N-1:0]  vec_in;
    fine_flags_t   fl_in;
    logic [CW-1:0] cand;
    logic [CW-1:0] probe;
    logic [CW-1:0] acc_nx;
    logic [CW-1:0] acc_r;
    fine_flags_t   fl_r;

    if (i == 0) begin : g_head
      assign acc_in = '0;
      assign vec_in = vec_i;
      assign fl_in  = flags_i;
    end else begin : g_body
      assign acc_in = g_step[i-1].acc_r;
      assign vec_in = g_step[i-1].g_keep.vec_r;
      assign fl_in  = g_step[i-1].fl_r;
    end

    always_comb begin
      cand   = acc_in | MASK;
      probe  = cand - CW'(1);
      acc_nx = vec_in[probe] ? acc_in : cand;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_r <= '0;
        fl_r  <= '0;
      end else begin
        acc_r <= acc_nx;
        fl_r  <= fl_in;
      end
    end

    // The tap vector is only needed by the stages that follow.
    if (i < CW - 1) begin : g_keep
      logic [N-1:0] vec_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vec_r <= '1;
        else        vec_r <= vec_in;
      end
    end
  end

  assign acc_o   = g_step[CW-1].acc_r;
  assign flags_o = g_step[CW-1].fl_r;
endmodule

// File: rtl/fine_out_stage.sv
module fine_out_stage
  import thermo_fine_pkg::*;
#(
  parameter int N  = 64,
  parameter int CW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] acc_i,
  input  fine_flags_t   flags_i,
  output logic [CW-1:0] code_o,
  output logic          valid_o,
  output logic          ovf_o
);
  localparam logic [CW-1:0] CODE_MAX = CW'(N - 1);

  logic [CW-1:0] code_nx;

  always_comb begin
    if (!flags_i.hit)      code_nx = '0;
    else if (flags_i.full) code_nx = CODE_MAX;
    else                   code_nx = acc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o  <= '0;
      valid_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      code_o  <= code_nx;
      valid_o <= flags_i.hit;
      ovf_o   <= flags_i.hit & flags_i.full;
    end
  end
endmodule

// File: rtl/thermo_fine_encoder.sv
module thermo_fine_encoder
  import thermo_fine_pkg::*;
#(
  parameter int N = 64,
  localparam int CW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  tap,
  output logic [CW-1:0] fine_code,
  output logic          fine_valid,
  output logic          chain_overflow
);
  logic [N-1:0]  tap_s;
  fine_flags_t   flags_s;
  logic [CW-1:0] acc_f;
  fine_flags_t   flags_f;

  tap_sync #(.W(N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (tap),
    .q     (tap_s)
  );

  assign flags_s.hit  = ~tap_s[0];
  assign flags_s.full = ~tap_s[N-1];

  fine_search #(.N(N), .CW(CW)) u_search (
    .clk     (clk),
    .rst_n   (rst_n),
    .vec_i   (tap_s),
    .flags_i (flags_s),
    .acc_o   (acc_f),
    .flags_o (flags_f)
  );

  fine_out_stage #(.N(N), .CW(CW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_i   (acc_f),
    .flags_i (flags_f),
    .code_o  (fine_code),
    .valid_o (fine_valid),
    .ovf_o   (chain_overflow)
  );
endmodule

// File: rtl/thermo_fine_encoder_chk.sv
module thermo_fine_encoder_chk #(
  parameter int N = 64,
  localparam int CW = $clog2(N),
  localparam int LAT = CW + 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  tap,
  input logic [CW-1:0] fine_code,
  input logic          fine_valid,
  input logic          chain_overflow
);
  // History of the hit decision at the input, LAT+1 samples deep.
  logic [LAT:0] hit_hist;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_hist <= '0;
    else        hit_hist <= {hit_hist[LAT-1:0], ~tap[0]};
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fine_valid == hit_hist[LAT]);

  assert_ovf_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chain_overflow |-> fine_valid);

  assert_ovf_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chain_overflow |-> (fine_code == CW'(N - 1)));

  assert_idle_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_valid |-> (fine_code == '0 && !chain_overflow));
endmodule

bind thermo_fine_encoder thermo_fine_encoder_chk #(.N(N)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tap            (tap),
  .fine_code      (fine_code),
  .fine_valid     (fine_valid),
  .chain_overflow (chain_overflow)
);

// File: tb/thermo_fine_encoder_bench.sv
module thermo_fine_encoder_bench;
  localparam int N   = 64;
  localparam int CW  = $clog2(N);
  localparam int LAT = CW + 2;

  typedef struct {
    int    lo;
    int    hi;
    logic  ev;
    logic  eo;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  tap = '1;
  logic [CW-1:0] fine_code;
  logic          fine_valid;
  logic          chain_overflow;

  int   checks = 0;
  int   errors = 0;
  int   nidx = 0;
  int   probe_k = 0;
  bit   probe_armed = 1'b0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;

  thermo_fine_encoder #(.N(N)) u_thermo_fine_encoder (
    .clk            (clk),
    .rst_n          (rst_n),
    .tap            (tap),
    .fine_code      (fine_code),
    .fine_valid     (fine_valid),
    .chain_overflow (chain_overflow)
  );

  function automatic logic [N-1:0] therm(input int z);
    logic [N-1:0] v = '1;
    for (int i = 0; i < z; i++) v[i] = 1'b0;
    return v;
  endfunction

  // Monitor: pop the item sampled LAT+1 negedges earlier and compare.
  task automatic monitor_step();
    exp_t e;
    if (probe_armed && fine_valid) begin
      checks++;
      if (nidx - probe_k != LAT + 1) begin
        errors++;
        $display("FAIL R4 latency: got %0d expected %0d", nidx - probe_k, LAT + 1);
      end
      probe_armed = 1'b0;
    end
    if (sb.size() == LAT + 1) begin
      e = sb.pop_front();
      checks++;
      if (fine_valid !== e.ev || chain_overflow !== e.eo ||
          int'(fine_code) < e.lo || int'(fine_code) > e.hi) begin
        errors++;
        $display("FAIL %s: got code=%0d valid=%0b ovf=%0b expected code=%0d..%0d valid=%0b ovf=%0b",
                 e.tag, fine_code, fine_valid, chain_overflow, e.lo, e.hi, e.ev, e.eo);
      end
    end
  endtask

  // Driver: present one sample and queue its expected result.
  task automatic drive(input logic [N-1:0] v, input int lo, input int hi,
                       input logic ev, input logic eo, input string tag);
    exp_t e;
    @(negedge clk);
    monitor_step();
    tap = v;
    e.lo = lo; e.hi = hi; e.ev = ev; e.eo = eo; e.tag = tag;
    sb.push_back(e);
    nidx++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive('1, 0, 0, 1'b0, 1'b0, "R2 idle");
  endtask

  initial begin
    logic [N-1:0] v;
    // R1: outputs held at zero under reset, even with a hit on the taps
    tap = '0;
    repeat (4) @(negedge clk);
    checks++;
    if (fine_code !== '0 || fine_valid !== 1'b0 || chain_overflow !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got code=%0d valid=%0b ovf=%0b expected 0 0 0",
               fine_code, fine_valid, chain_overflow);
    end
    tap = '1;
    @(negedge clk);
    rst_n = 1'b1;

    idle(LAT + 3);

    // R3 / R4: back-to-back sweep of every clean boundary
    for (int z = 1; z < N; z++) begin
      if (z == N - 1) drive(therm(z), z, z, 1'b1, 1'b0, "R6 top tap only");
      else            drive(therm(z), z, z, 1'b1, 1'b0, "R3 clean boundary");
    end

    // R5: line low end to end
    drive('0, N - 1, N - 1, 1'b1, 1'b1, "R5 overflow");
    drive(therm(N - 1), N - 1, N - 1, 1'b1, 1'b0, "R6 no overflow");
    drive('0, N - 1, N - 1, 1'b1, 1'b1, "R5 overflow repeat");
    idle(2);

    // R8: entry tap high means no hit, whatever lies above
    v = '0; v[0] = 1'b1;
    drive(v, 0, 0, 1'b0, 1'b0, "R8 entry high rest low");
    v = '1; v[20:5] = '0;
    drive(v, 0, 0, 1'b0, 1'b0, "R8 entry high mid low");
    drive(therm(7), 7, 7, 1'b1, 1'b0, "R3 after no-hit");

    // R7: one-bit bubble next to the boundary
    foreach (sb[i]) ; // keep order explicit
    for (int k = 0; k < 5; k++) begin
      int z;
      case (k)
        0: z = 3;
        1: z = 10;
        2: z = 32;
        3: z = 45;
        default: z = N - 2;
      endcase
      v = therm(z);
      v[z-1] = 1'b1;
      v[z]   = 1'b0;
      drive(v, z - 1, z + 1, 1'b1, 1'b0, "R7 bubble");
    end

    // R4: lone hit between idle samples, exact latency
    idle(LAT + 3);
    @(negedge clk);
    monitor_step();
    tap = therm(12);
    sb.push_back('{lo: 12, hi: 12, ev: 1'b1, eo: 1'b0, tag: "R4 lone hit"});
    probe_k = nidx;
    probe_armed = 1'b1;
    nidx++;
    idle(LAT + 4);

    if (probe_armed) begin
      checks++;
      errors++;
      $display("FAIL R4 latency: got no result expected %0d cycles", LAT + 1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule